// File: doc/BRIEF.md
# Load-Reserved / Store-Conditional Reservation Tracker

This block keeps the reservation state of one hardware thread for atomic load-reserved and store-conditional pairs. Each load-reserved places its physical address, rounded down to a 16-byte granule, on a small stack of reservations. Several reservations may be outstanding at once. A store-conditional is judged only against the newest one. A coherence snoop whose cache-block address matches the newest reservation removes that reservation, and older ones stay in place.

The store-conditional outcome is reported as a code. The code is 0 for failure, 1 for success, and 2 for success on an uncacheable access. A counter of consecutive failed store-conditionals runs beside the stack. It raises a one-cycle warning each time the count reaches a whole multiple of a parameterised interval.

When a snoop, a store-conditional and a load-reserved arrive in the same cycle, they act in that order. The memory system that produces these events is outside the block.

Top module: `resv_stack_tracker`

## Requirements
- R1: After reset the stack is empty, `sc_valid`, `sc_code`, `fail_cnt` and `fail_warn` are all 0.
- R2: A load-reserved pushes `lr_addr` with its 4 low bits forced to zero, so a later store-conditional to any address in the same 16-byte granule matches it.
- R3: `sc_valid` is high in the cycle after each `sc_req` cycle, and low otherwise. `sc_code` is then 1 on a match, 2 on a match with `sc_uncached` high, and 0 on a miss. A miss is an empty stack or a newest entry that differs from `sc_addr` with its 4 low bits cleared. `sc_code` is 0 whenever `sc_valid` is low.
- R4: A store-conditional never removes a reservation, whether it succeeds or fails.
- R5: Only the newest reservation can make a store-conditional succeed. Older reservations do not match.
- R6: A snoop compares `snp_addr & snp_mask` with `newest & snp_mask` and pops the newest entry on equality. A snoop that does not match, or that arrives while the stack is empty, changes nothing.
- R7: The stack holds `DEPTH` entries. A load-reserved into a full stack discards the oldest entry.
- R8: `fail_cnt` rises by one with each failed store-conditional and returns to 0 on a successful one. It is updated in the same cycle as `sc_code`.
- R9: `fail_warn` pulses for one cycle, together with the failing result, whenever `fail_cnt` becomes a non-zero multiple of `WARN_EVERY` (default 10000).
- R10: Events in the same cycle are applied as snoop first, then store-conditional, then load-reserved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lr_req | input | 1 | Load-reserved event |
| lr_addr | input | AW | Physical address of the load-reserved |
| sc_req | input | 1 | Store-conditional event |
| sc_addr | input | AW | Physical address of the store-conditional |
| sc_uncached | input | 1 | Store-conditional targets uncacheable memory |
| snp_req | input | 1 | Coherence snoop event |
| snp_addr | input | AW | Snoop address |
| snp_mask | input | AW | Cache-block mask applied to both sides of the snoop compare |
| sc_valid | output | 1 | Store-conditional result is present |
| sc_code | output | 2 | 0 fail, 1 success, 2 uncacheable success |
| fail_cnt | output | CNT_W | Consecutive failed store-conditionals |
| fail_warn | output | 1 | One-cycle pulse at every WARN_EVERY-th consecutive failure |

## Verification
Every result is registered once. The code, the failure count and the warning for a store-conditional presented before a rising edge appear just after that edge. A snoop or load-reserved in the same cycle takes effect in that same edge, so it affects a store-conditional in the same cycle only according to the R10 order.

The bench drives each cycle's events on the falling edge and advances a queue-based model for that cycle. It then compares all four outputs on the following falling edge, one full cycle later. The warning is exercised with an unbroken run of 10000 failures, and the check lands exactly on the failing result that completes the run.

// File: rtl/resv_pkg.sv
package resv_pkg;
  typedef enum logic [1:0] {
    SC_FAIL        = 2'd0,
    SC_OK          = 2'd1,
    SC_OK_UNCACHED = 2'd2
  } sc_code_e;
endpackage

// File: rtl/resv_lifo.sv
// Reservation stack as a circular buffer: a write pointer marks the next free
// slot, an occupancy count saturates at DEPTH so a push when full overwrites
// the oldest slot. DEPTH must be a power of two, at least 2.
module resv_lifo #(
  parameter int AW    = 32,
  parameter int DEPTH = 4,
  localparam int PW   = $clog2(DEPTH),
  localparam int OW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [AW-1:0] push_addr,
  input  logic          pop,
  output logic [AW-1:0] top,
  output logic [AW-1:0] below,
  output logic [OW-1:0] occ
);
  logic [AW-1:0] mem [DEPTH];
  logic [PW-1:0] wp;
  logic [PW-1:0] top_idx;
  logic [PW-1:0] below_idx;

  assign top_idx   = wp - PW'(1);
  assign below_idx = wp - PW'(2);
  assign top       = mem[top_idx];
  assign below     = mem[below_idx];

  // storage: no reset, single write port
  always_ff @(posedge clk) begin
    if (push) begin
      if (pop) mem[top_idx] <= push_addr;
      else     mem[wp]      <= push_addr;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      occ <= '0;
    end else if (push && !pop) begin
      wp <= wp + PW'(1);
      if (occ != OW'(DEPTH)) occ <= occ + OW'(1);
    end else if (pop && !push) begin
      wp  <= wp - PW'(1);
      occ <= occ - OW'(1);
    end
  end
endmodule

// File: rtl/resv_fail_ctr.sv
// Consecutive-failure counter with a modulo phase counter for the warning.
module resv_fail_ctr #(
  parameter int CNT_W      = 32,
  parameter int WARN_EVERY = 10000,
  localparam int PHW       = (WARN_EVERY > 1) ? $clog2(WARN_EVERY) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fail,
  input  logic             pass,
  output logic [CNT_W-1:0] cnt,
  output logic             warn
);
  logic [PHW-1:0] phase;

  always_ff @(posedge clk) begin
    if (rst || pass) begin
      cnt   <= '0;
      phase <= '0;
      warn  <= 1'b0;
    end else if (fail) begin
      cnt <= cnt + CNT_W'(1);
      if (phase == PHW'(WARN_EVERY - 1)) begin
        phase <= '0;
        warn  <= 1'b1;
      end else begin
        phase <= phase + PHW'(1);
        warn  <= 1'b0;
      end
    end else begin
      warn <= 1'b0;
    end
  end
endmodule

// File: rtl/resv_stack_tracker.sv
module resv_stack_tracker #(
  parameter int AW         = 32,
  parameter int DEPTH      = 4,
  parameter int GRAN_BITS  = 4,
  parameter int CNT_W      = 32,
  parameter int WARN_EVERY = 10000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lr_req,
  input  logic [AW-1:0]    lr_addr,
  input  logic             sc_req,
  input  logic [AW-1:0]    sc_addr,
  input  logic             sc_uncached,
  input  logic             snp_req,
  input  logic [AW-1:0]    snp_addr,
  input  logic [AW-1:0]    snp_mask,
  output logic             sc_valid,
  output logic [1:0]       sc_code,
  output logic [CNT_W-1:0] fail_cnt,
  output logic             fail_warn
);
  import resv_pkg::*;

  localparam int OW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] GRAN_MASK = {{(AW-GRAN_BITS){1'b1}}, {GRAN_BITS{1'b0}}};

  logic [AW-1:0] top, below, eff_top;
  logic [OW-1:0] occ;
  logic          snoop_hit, eff_nonempty, sc_match;
  sc_code_e      code_next;

  resv_lifo #(.AW(AW), .DEPTH(DEPTH)) u_lifo (
    .clk       (clk),
    .rst       (rst),
    .push      (lr_req),
    .push_addr (lr_addr & GRAN_MASK),
    .pop       (snoop_hit),
    .top       (top),
    .below     (below),
    .occ       (occ)
  );

  // step 1: snoop against the current newest entry
  assign snoop_hit = snp_req && (occ != '0) &&
                     ((snp_addr & snp_mask) == (top & snp_mask));

  // step 2: store-conditional sees the stack as left by the snoop
  assign eff_top      = snoop_hit ? below : top;
  assign eff_nonempty = snoop_hit ? (occ > OW'(1)) : (occ != '0);
  assign sc_match     = sc_req && eff_nonempty && (eff_top == (sc_addr & GRAN_MASK));

  always_comb begin
    if (!sc_match)        code_next = SC_FAIL;
    else if (sc_uncached) code_next = SC_OK_UNCACHED;
    else                  code_next = SC_OK;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sc_valid <= 1'b0;
      sc_code  <= 2'd0;
    end else begin
      sc_valid <= sc_req;
      sc_code  <= sc_req ? code_next : SC_FAIL;
    end
  end

  resv_fail_ctr #(.CNT_W(CNT_W), .WARN_EVERY(WARN_EVERY)) u_fail (
    .clk  (clk),
    .rst  (rst),
    .fail (sc_req && !sc_match),
    .pass (sc_match),
    .cnt  (fail_cnt),
    .warn (fail_warn)
  );
endmodule

// File: rtl/resv_checker.sv
module resv_checker #(
  parameter int DEPTH = 4,
  parameter int CNT_W = 32,
  localparam int OW   = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             lr_req,
  input logic             sc_req,
  input logic             snp_req,
  input logic             sc_valid,
  input logic [1:0]       sc_code,
  input logic [CNT_W-1:0] fail_cnt,
  input logic             fail_warn,
  input logic [OW-1:0]    occ
);
  a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!sc_valid && fail_cnt == '0 && !fail_warn));

  a_r3_valid_follows_req: assert property (@(posedge clk) disable iff (rst)
    sc_valid == $past(sc_req));

  a_r3_idle_code_zero: assert property (@(posedge clk) disable iff (rst)
    !sc_valid |-> sc_code == 2'd0);

  a_r3_code_legal: assert property (@(posedge clk) disable iff (rst)
    sc_valid |-> sc_code != 2'd3);

  a_r4_sc_keeps_depth: assert property (@(posedge clk) disable iff (rst)
    (sc_req && !lr_req && !snp_req) |=> occ == $past(occ));

  a_r2_lr_grows: assert property (@(posedge clk) disable iff (rst)
    (lr_req && !snp_req && occ < OW'(DEPTH)) |=> occ == $past(occ) + OW'(1));

  a_r7_depth_bound: assert property (@(posedge clk) disable iff (rst)
    occ <= OW'(DEPTH));

  a_r8_clear_on_pass: assert property (@(posedge clk) disable iff (rst)
    (sc_valid && sc_code != 2'd0) |-> fail_cnt == '0);

  a_r8_inc_on_fail: assert property (@(posedge clk) disable iff (rst)
    (sc_valid && sc_code == 2'd0) |-> fail_cnt == $past(fail_cnt) + CNT_W'(1));

  a_r9_warn_with_fail: assert property (@(posedge clk) disable iff (rst)
    fail_warn |-> (sc_valid && sc_code == 2'd0));
endmodule

bind resv_stack_tracker resv_checker #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .lr_req    (lr_req),
  .sc_req    (sc_req),
  .snp_req   (snp_req),
  .sc_valid  (sc_valid),
  .sc_code   (sc_code),
  .fail_cnt  (fail_cnt),
  .fail_warn (fail_warn),
  .occ       (occ)
);

// File: tb/sim_resv_stack_tracker.sv
module sim_resv_stack_tracker;
  localparam int AW = 32, DEPTH = 4, CNT_W = 32, WARN_EVERY = 10000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic lr_req = 0, sc_req = 0, sc_uncached = 0, snp_req = 0;
  logic [AW-1:0] lr_addr = '0, sc_addr = '0, snp_addr = '0, snp_mask = '0;
  logic sc_valid, fail_warn;
  logic [1:0] sc_code;
  logic [CNT_W-1:0] fail_cnt;

  always #4 clk = ~clk; // 125 MHz

  resv_stack_tracker #(.AW(AW), .DEPTH(DEPTH), .CNT_W(CNT_W), .WARN_EVERY(WARN_EVERY)) u0 (
    .clk(clk), .rst(rst),
    .lr_req(lr_req), .lr_addr(lr_addr),
    .sc_req(sc_req), .sc_addr(sc_addr), .sc_uncached(sc_uncached),
    .snp_req(snp_req), .snp_addr(snp_addr), .snp_mask(snp_mask),
    .sc_valid(sc_valid), .sc_code(sc_code), .fail_cnt(fail_cnt), .fail_warn(fail_warn)
  );

  int n_checks = 0;
  int n_fail = 0;
  string cur_req = "R1";

  // reference model
  logic [AW-1:0] q[$];
  int  m_fcnt = 0;
  logic e_valid = 0, e_warn = 0;
  logic [1:0] e_code = 0;
  localparam logic [AW-1:0] GM = 32'hFFFF_FFF0;

  task automatic check(input string what, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", cur_req, what, act, exp);
    end
  endtask

  // one cycle: drive at falling edge, model, compare at next falling edge
  task automatic cyc(input logic lr, input logic [AW-1:0] la,
                     input logic sc, input logic [AW-1:0] sa, input logic unc,
                     input logic sn, input logic [AW-1:0] sna, input logic [AW-1:0] snm);
    lr_req = lr; lr_addr = la; sc_req = sc; sc_addr = sa; sc_uncached = unc;
    snp_req = sn; snp_addr = sna; snp_mask = snm;
    // R10 order: snoop, SC, LR
    if (sn && q.size() > 0 && ((sna & snm) == (q[$] & snm))) void'(q.pop_back());
    e_valid = sc; e_code = 0; e_warn = 0;
    if (sc) begin
      if (q.size() > 0 && q[$] == (sa & GM)) begin
        e_code = unc ? 2'd2 : 2'd1;
        m_fcnt = 0;
      end else begin
        m_fcnt++;
        e_warn = (m_fcnt % WARN_EVERY) == 0;
      end
    end
    if (lr) begin
      q.push_back(la & GM);
      if (q.size() > DEPTH) void'(q.pop_front());
    end
    @(posedge clk);
    @(negedge clk);
    check("sc_valid", sc_valid, e_valid);
    check("sc_code", sc_code, e_code);
    check("fail_cnt", fail_cnt, m_fcnt);
    check("fail_warn", fail_warn, e_warn);
  endtask

  task automatic idle();  cyc(0, 0, 0, 0, 0, 0, 0, 0); endtask
  task automatic lr_op(input logic [AW-1:0] a); cyc(1, a, 0, 0, 0, 0, 0, 0); endtask
  task automatic sc_op(input logic [AW-1:0] a, input logic u); cyc(0, 0, 1, a, u, 0, 0, 0); endtask
  task automatic snp_op(input logic [AW-1:0] a, input logic [AW-1:0] m); cyc(0, 0, 0, 0, 0, 1, a, m); endtask

  initial begin
    #(8 * 200000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state, empty stack
    cur_req = "R1"; idle(); sc_op(32'h0, 0);
    // R2: granule rounding
    cur_req = "R2"; lr_op(32'h1234_5678); sc_op(32'h1234_567C, 0);
    // R3: uncacheable code, miss
    cur_req = "R3"; sc_op(32'h1234_5671, 1); sc_op(32'h1234_5680, 0);
    // R4: SC does not pop
    cur_req = "R4"; sc_op(32'h1234_5670, 0); sc_op(32'h1234_5670, 0);
    // R5: only newest eligible
    cur_req = "R5"; lr_op(32'h2000); lr_op(32'h3000); sc_op(32'h2000, 0); sc_op(32'h3004, 0);
    // R6: mismatched snoop, matching snoop, empty snoop
    cur_req = "R6"; snp_op(32'h9000, 32'hFFFF_FFC0); sc_op(32'h3000, 0);
    snp_op(32'h3010, 32'hFFFF_FFC0); sc_op(32'h2000, 0);
    snp_op(32'h2000, 32'hFFFF_FFC0); snp_op(32'h1234_5670, 32'hFFFF_FFFF);
    snp_op(32'h1234_5670, 32'hFFFF_FFFF); sc_op(32'h1234_5670, 0);
    // R7: overflow discards oldest
    cur_req = "R7";
    for (int k = 1; k <= DEPTH + 1; k++) lr_op(32'h100 * k);
    for (int k = 0; k < DEPTH - 1; k++) snp_op(32'h500 - 32'h100 * k, 32'hFFFF_FFF0);
    sc_op(32'h200, 0); snp_op(32'h200, 32'hFFFF_FFF0); sc_op(32'h100, 0);
    // R8: failures accumulate, success clears
    cur_req = "R8"; sc_op(32'h40, 0); sc_op(32'h40, 0); lr_op(32'h40); sc_op(32'h40, 0);
    // R10: same-cycle ordering
    cur_req = "R10";
    cyc(1, 32'h40, 1, 32'h40, 0, 1, 32'h40, 32'hFFFF_FFF0); // snoop pops, SC fails, LR re-pushes
    sc_op(32'h40, 0);
    snp_op(32'h40, 32'hFFFF_FFF0);
    cyc(1, 32'h80, 1, 32'h80, 0, 0, 0, 0);                   // SC before LR: fails
    sc_op(32'h80, 1);
    // R9: warning at the WARN_EVERY-th consecutive failure
    cur_req = "R9";
    for (int k = 0; k < WARN_EVERY + 2; k++) sc_op(32'hF00, 0);
    idle();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule